// File: doc/BRIEF.md
# Domain-Isolated Way-Partitioned Cache Tag Controller

This block holds the tag, valid, dirty and replacement state of a shared set-associative last-level cache. Every way can be owned by one or more protection domains through a per-domain way mask. Each lookup is confined to the ways of the requesting domain: a tag match counts only inside those ways, the fill victim is chosen only among them, and only that domain's own pseudo-LRU tree for the set is updated. A domain therefore cannot infer another domain's activity from hits or from the replacement order it observes.

A requesting core presents a line address, an access kind and its three domain identifiers: one for instruction fetches, one for loads and one for stores. The kind selects which identifier applies. Masks are loaded through a small configuration write port. A lookup is accepted in one cycle and its result comes back one cycle later through a registered valid/ready response. The response gives hit or miss, the way used, and on a miss whether the evicted line needs a write-back and what its tag was. Data storage and the refill path are outside the block.

Top module: `dwp_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, every replacement tree bit is zero, every way mask is zero, no response is pending and the block is ready for a request.
- R2: The access kind picks the domain: 2'b00 uses the fetch domain, 2'b01 and 2'b11 use the load domain, and 2'b10 uses the store domain. Only 2'b10 is a write.
- R3: A lookup hits only on a valid line with a matching tag in a way whose bit is set in the requester's mask. The lowest such way is reported. A match in any other way is a miss.
- R4: On a miss, the filled way is inside the requester's mask. The lowest-numbered invalid way in the mask wins. The line is then valid with the new tag.
- R5: When every masked way is valid, the victim comes from the requester's own tree for the set. The tree uses heap-numbered nodes 1..WAYS-1, where node n has children 2n and 2n+1. At each node the walk goes to the only child subtree that holds masked ways. If both subtrees hold masked ways, it goes right when the node bit is 1. Each access sets every node on the used way's path so that it points away from that way.
- R6: An access updates only the requesting domain's tree. Another domain's later victim choice in the same set is the same as if the access had never happened.
- R7: A store hit marks the line dirty. A store miss fills the line dirty and a read miss fills it clean. A miss whose victim was valid and dirty reports a write-back together with the victim's old tag.
- R8: A request whose selected mask is all zero returns the error flag with no hit. It fills nothing and changes no replacement state.
- R9: A mask write changes only requests accepted after the write cycle. A request accepted in the same cycle as the write uses the old mask.
- R10: The response appears in the cycle after acceptance. It is held stable while the response is not taken. A request is accepted when no response is pending or the pending one is being taken in the same cycle.
- R11: The same line can sit in two ways owned by two different domains. Each domain hits only its own copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when valid |
| reqLine | input | LINE_W | Line address: tag above the set index |
| reqKind | input | 2 | Access kind (fetch, load, store) |
| fetchDom | input | DOM_W | Domain used for instruction fetches |
| loadDom | input | DOM_W | Domain used for loads |
| storeDom | input | DOM_W | Domain used for stores |
| cfgWe | input | 1 | Way-mask write strobe |
| cfgDom | input | DOM_W | Domain whose mask is written |
| cfgMask | input | WAYS | New way mask |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response taken |
| rspErr | output | 1 | Requester's mask was empty |
| rspHit | output | 1 | Lookup hit |
| rspWay | output | WAY_W | Hit way, or filled way on a miss |
| rspEvictDirty | output | 1 | Victim needs a write-back |
| rspEvictTag | output | TAG_W | Tag of the evicted line |

## Verification
The hardest state to reach is a set that is full inside a domain's mask, where another domain shares some of those ways and has been active in the same set. Only there does a leak through the replacement order show up as a different victim. The stimulus fills a set with one domain, rotates that domain's tree with a repeat access, and then misses from a second domain that shares the ways. Each domain's victim is then checked against a value worked out by hand. A long randomized sweep over a small four-set, four-way, four-domain build follows. It uses overlapping, disjoint and empty masks and compares every response with an arithmetic model in the bench.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH    = 2'b00,
    KIND_LOAD     = 2'b01,
    KIND_STORE    = 2'b10,
    KIND_LOAD_ALT = 2'b11
  } acc_kind_e;

  // Strobes from control to the tag/replacement datapath
  typedef struct packed {
    logic touch;     // update replacement tree of the requester
    logic fill;      // allocate actWay with the request tag
    logic makeDirty; // access is a store
  } dwp_strobe_t;

endpackage

// File: rtl/dwp_victim_pick.sv
module dwp_victim_pick #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int LVLS = $clog2(WAYS)
) (
  input  logic [WAYS-1:1]  treeBits,
  input  logic [WAYS-1:0]  mask,
  input  logic [WAYS-1:0]  validVec,
  output logic [WAY_W-1:0] victim
);

  logic [WAYS-1:0] freeVec;
  logic [WAYS-1:1] goRight;

  // Per-node steering, restricted to masked ways
  always_comb begin
    goRight = '0;
    for (int n = 1; n < WAYS; n++) begin
      int lvl;
      int span;
      int base;
      logic leftAny;
      logic rightAny;
      lvl = 0;
      for (int l = 0; l < LVLS; l++) begin
        if (n >= (1 << l)) lvl = l;
      end
      span = WAYS >> lvl;
      base = (n - (1 << lvl)) * span;
      leftAny = 1'b0;
      rightAny = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if (mask[w] && w >= base && w < base + span / 2) leftAny = 1'b1;
        if (mask[w] && w >= base + span / 2 && w < base + span) rightAny = 1'b1;
      end
      goRight[n] = !leftAny || (rightAny && treeBits[n]);
    end
  end

  always_comb begin
    int cur;
    int freeWay;
    freeVec = mask & ~validVec;
    freeWay = 0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (freeVec[w]) freeWay = w;
    end
    cur = 1;
    for (int l = 0; l < LVLS; l++) begin
      int step;
      step = 0;
      for (int n = 1; n < WAYS; n++) begin
        if (n == cur) step = goRight[n] ? 1 : 0;
      end
      cur = 2 * cur + step;
    end
    victim = (|freeVec) ? WAY_W'(freeWay) : WAY_W'(cur - WAYS);
  end

endmodule

// File: rtl/dwp_datapath.sv
module dwp_datapath
  import dwp_pkg::*;
#(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  parameter int DOMAINS = 4,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int DOM_W = $clog2(DOMAINS),
  localparam int LVLS = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] setIdx,
  input  logic [TAG_W-1:0] tagIn,
  input  logic [DOM_W-1:0] dom,
  input  logic [WAYS-1:0]  mask,
  input  dwp_strobe_t      strobe,
  input  logic [WAY_W-1:0] actWay,
  output logic             lkHit,
  output logic [WAY_W-1:0] lkHitWay,
  output logic [WAY_W-1:0] lkVictim,
  output logic             lkVicDirty,
  output logic [TAG_W-1:0] lkVicTag
);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [WAYS-1:0]  dirtyMem [SETS];
  logic [WAYS-1:1]  treeMem  [SETS][DOMAINS];

  logic [WAYS-1:0]  matchVec;
  logic [WAYS-1:1]  treeCur;
  logic [WAYS-1:1]  treeNext;

  assign treeCur = treeMem[setIdx][dom];

  // Hit detection confined to the requester's ways
  always_comb begin
    lkHitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      matchVec[w] = validMem[setIdx][w] && mask[w] && (tagMem[setIdx][w] == tagIn);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) lkHitWay = WAY_W'(w);
    end
    lkHit = |matchVec;
  end

  dwp_victim_pick #(.WAYS(WAYS)) pick_i (
    .treeBits (treeCur),
    .mask     (mask),
    .validVec (validMem[setIdx]),
    .victim   (lkVictim)
  );

  assign lkVicDirty = validMem[setIdx][lkVictim] & dirtyMem[setIdx][lkVictim];
  assign lkVicTag   = tagMem[setIdx][lkVictim];

  // Path update: each node on the way's path points to the other child
  always_comb begin
    int leaf;
    leaf = int'(actWay) + WAYS;
    treeNext = treeCur;
    for (int n = 1; n < WAYS; n++) begin
      for (int l = 0; l < LVLS; l++) begin
        if ((leaf >> (LVLS - l)) == n) begin
          treeNext[n] = ((leaf >> (LVLS - l - 1)) & 1) == 0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
        for (int d = 0; d < DOMAINS; d++) treeMem[s][d] <= '0;
      end
    end else if (strobe.touch) begin
      treeMem[setIdx][dom] <= treeNext;
      if (strobe.fill) begin
        validMem[setIdx][actWay] <= 1'b1;
        dirtyMem[setIdx][actWay] <= strobe.makeDirty;
      end else if (strobe.makeDirty) begin
        dirtyMem[setIdx][actWay] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.touch && strobe.fill) tagMem[setIdx][actWay] <= tagIn;
  end

endmodule

// File: rtl/dwp_control.sv
module dwp_control
  import dwp_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int DOMAINS = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS),
  localparam int DOM_W = $clog2(DOMAINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqKind,
  input  logic [DOM_W-1:0] fetchDom,
  input  logic [DOM_W-1:0] loadDom,
  input  logic [DOM_W-1:0] storeDom,
  input  logic             cfgWe,
  input  logic [DOM_W-1:0] cfgDom,
  input  logic [WAYS-1:0]  cfgMask,
  input  logic             lkHit,
  input  logic [WAY_W-1:0] lkHitWay,
  input  logic [WAY_W-1:0] lkVictim,
  input  logic             lkVicDirty,
  input  logic [TAG_W-1:0] lkVicTag,
  output logic [DOM_W-1:0] selDom,
  output logic [WAYS-1:0]  selMask,
  output dwp_strobe_t      strobe,
  output logic [WAY_W-1:0] actWay,
  output logic             rspValid,
  input  logic             rspReady,
  output logic             rspErr,
  output logic             rspHit,
  output logic [WAY_W-1:0] rspWay,
  output logic             rspEvictDirty,
  output logic [TAG_W-1:0] rspEvictTag
);

  logic [WAYS-1:0] maskReg [DOMAINS];
  logic accept;
  logic isWrite;
  logic maskEmpty;

  always_comb begin
    unique case (acc_kind_e'(reqKind))
      KIND_FETCH: selDom = fetchDom;
      KIND_STORE: selDom = storeDom;
      default:    selDom = loadDom;
    endcase
  end

  assign isWrite   = (acc_kind_e'(reqKind) == KIND_STORE);
  assign selMask   = maskReg[selDom];
  assign maskEmpty = (selMask == '0);
  assign reqReady  = !rspValid || rspReady;
  assign accept    = reqValid && reqReady;
  assign actWay    = lkHit ? lkHitWay : lkVictim;

  always_comb begin
    strobe.touch     = accept && !maskEmpty;
    strobe.fill      = accept && !maskEmpty && !lkHit;
    strobe.makeDirty = accept && !maskEmpty && isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < DOMAINS; d++) maskReg[d] <= '0;
    end else if (cfgWe) begin
      maskReg[cfgDom] <= cfgMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspErr        <= 1'b0;
      rspHit        <= 1'b0;
      rspWay        <= '0;
      rspEvictDirty <= 1'b0;
      rspEvictTag   <= '0;
    end else if (accept) begin
      rspValid      <= 1'b1;
      rspErr        <= maskEmpty;
      rspHit        <= !maskEmpty && lkHit;
      rspWay        <= maskEmpty ? '0 : actWay;
      rspEvictDirty <= !maskEmpty && !lkHit && lkVicDirty;
      rspEvictTag   <= (!maskEmpty && !lkHit) ? lkVicTag : '0;
    end else if (rspReady) begin
      rspValid <= 1'b0;
    end
  end

endmodule

// File: rtl/dwp_cache_ctrl.sv
module dwp_cache_ctrl
  import dwp_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int SETS = 64,
  parameter int WAYS = 8,
  parameter int DOMAINS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = LINE_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int DOM_W = $clog2(DOMAINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [1:0]        reqKind,
  input  logic [DOM_W-1:0]  fetchDom,
  input  logic [DOM_W-1:0]  loadDom,
  input  logic [DOM_W-1:0]  storeDom,
  input  logic              cfgWe,
  input  logic [DOM_W-1:0]  cfgDom,
  input  logic [WAYS-1:0]   cfgMask,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspErr,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay,
  output logic              rspEvictDirty,
  output logic [TAG_W-1:0]  rspEvictTag
);

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] tagIn;
  logic [DOM_W-1:0] selDom;
  logic [WAYS-1:0]  selMask;
  dwp_strobe_t      strobe;
  logic [WAY_W-1:0] actWay;
  logic             lkHit;
  logic [WAY_W-1:0] lkHitWay;
  logic [WAY_W-1:0] lkVictim;
  logic             lkVicDirty;
  logic [TAG_W-1:0] lkVicTag;

  assign setIdx = reqLine[IDX_W-1:0];
  assign tagIn  = reqLine[LINE_W-1:IDX_W];

  dwp_control #(.WAYS(WAYS), .DOMAINS(DOMAINS), .TAG_W(TAG_W)) ctrl_i (
    .clk, .rstN, .reqValid, .reqReady, .reqKind, .fetchDom, .loadDom, .storeDom,
    .cfgWe, .cfgDom, .cfgMask, .lkHit, .lkHitWay, .lkVictim, .lkVicDirty, .lkVicTag,
    .selDom, .selMask, .strobe, .actWay, .rspValid, .rspReady, .rspErr, .rspHit,
    .rspWay, .rspEvictDirty, .rspEvictTag
  );

  dwp_datapath #(.SETS(SETS), .WAYS(WAYS), .DOMAINS(DOMAINS), .TAG_W(TAG_W)) dp_i (
    .clk, .rstN, .setIdx, .tagIn, .dom(selDom), .mask(selMask), .strobe, .actWay,
    .lkHit, .lkHitWay, .lkVictim, .lkVicDirty, .lkVicTag
  );

endmodule

// File: rtl/dwp_checker.sv
module dwp_checker #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspReady,
  input logic             rspErr,
  input logic             rspHit,
  input logic [WAY_W-1:0] rspWay,
  input logic             rspEvictDirty,
  input logic [WAYS-1:0]  selMask
);

  logic            freshRsp;
  logic [WAYS-1:0] maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freshRsp <= 1'b0;
      maskQ    <= '0;
    end else begin
      freshRsp <= reqValid && reqReady;
      maskQ    <= selMask;
    end
  end

  a_r10_ready_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> reqReady);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspHit) && $stable(rspWay) && $stable(rspErr));

  a_r3_hit_in_mask: assert property (@(posedge clk) disable iff (!rstN)
    freshRsp && rspHit |-> maskQ[rspWay]);

  a_r4_fill_in_mask: assert property (@(posedge clk) disable iff (!rstN)
    freshRsp && !rspHit && !rspErr |-> maskQ[rspWay]);

  a_r8_err_iff_empty: assert property (@(posedge clk) disable iff (!rstN)
    freshRsp |-> (rspErr == (maskQ == '0)));

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspErr |-> !rspHit && !rspEvictDirty);

endmodule

bind dwp_cache_ctrl dwp_checker #(.WAYS(WAYS)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspReady(rspReady), .rspErr(rspErr), .rspHit(rspHit),
  .rspWay(rspWay), .rspEvictDirty(rspEvictDirty), .selMask(selMask)
);

// File: tb/dwp_cache_ctrl_tb_top.sv
module dwp_cache_ctrl_tb_top;

  localparam int LINE_W = 10;
  localparam int SETS = 4;
  localparam int WAYS = 4;
  localparam int DOMAINS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [9:0] reqLine = '0;
  logic [1:0] reqKind = '0;
  logic [1:0] fetchDom = '0, loadDom = '0, storeDom = '0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgDom = '0;
  logic [3:0] cfgMask = '0;
  logic rspValid;
  logic rspReady = 1'b1;
  logic rspErr, rspHit, rspEvictDirty;
  logic [1:0] rspWay;
  logic [7:0] rspEvictTag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dwp_cache_ctrl #(.LINE_W(LINE_W), .SETS(SETS), .WAYS(WAYS), .DOMAINS(DOMAINS)) dut_i (
    .clk, .rstN, .reqValid, .reqReady, .reqLine, .reqKind, .fetchDom, .loadDom, .storeDom,
    .cfgWe, .cfgDom, .cfgMask, .rspValid, .rspReady, .rspErr, .rspHit, .rspWay,
    .rspEvictDirty, .rspEvictTag
  );

  // Reference model
  int  mTag [4][4];
  bit  mV   [4][4];
  bit  mD   [4][4];
  bit  mT   [4][4][4];  // [set][dom][node 1..3]
  bit [3:0] mMask [4];
  int eErr, eHit, eWay, eEvD, eEvT;

  function automatic int pickVictim(int s, int d);
    bit [3:0] m = mMask[d];
    int r, lo, nb;
    for (int w = 0; w < 4; w++) if (m[w] && !mV[s][w]) return w;
    r = !(m[0] | m[1]) ? 1 : (!(m[2] | m[3]) ? 0 : int'(mT[s][d][1]));
    lo = 2 * r;
    nb = r ? int'(mT[s][d][3]) : int'(mT[s][d][2]);
    if (!m[lo]) return lo + 1;
    if (!m[lo + 1]) return lo;
    return lo + nb;
  endfunction

  task automatic touch(int s, int d, int w);
    mT[s][d][1] = (w < 2);
    if (w < 2) mT[s][d][2] = (w == 0);
    else       mT[s][d][3] = (w == 2);
  endtask

  task automatic predict(int tag, int s, int kind, int fd, int ld, int sd);
    int d = (kind == 0) ? fd : ((kind == 2) ? sd : ld);
    bit wr = (kind == 2);
    bit [3:0] m = mMask[d];
    eErr = (m == 0); eHit = 0; eWay = 0; eEvD = 0; eEvT = 0;
    if (!eErr) begin
      for (int w = 0; w < 4; w++)
        if (!eHit && m[w] && mV[s][w] && mTag[s][w] == tag) begin eHit = 1; eWay = w; end
      if (!eHit) begin
        eWay = pickVictim(s, d);
        eEvD = mV[s][eWay] && mD[s][eWay];
        eEvT = mTag[s][eWay];
        mTag[s][eWay] = tag; mV[s][eWay] = 1; mD[s][eWay] = wr;
      end else if (wr) mD[s][eWay] = 1;
      touch(s, d, eWay);
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkRsp(string req);
    chk(req, "rspValid", int'(rspValid), 1);
    chk(req, "err", int'(rspErr), eErr);
    if (!eErr) begin
      chk(req, "hit", int'(rspHit), eHit);
      chk(req, "way", int'(rspWay), eWay);
      if (!eHit) chk(req, "evictDirty", int'(rspEvictDirty), eEvD);
      if (eEvD != 0) chk(req, "evictTag", int'(rspEvictTag), eEvT);
    end
  endtask

  task automatic drive(int tag, int s, int kind, int fd, int ld, int sd);
    reqValid = 1'b1;
    reqLine = {8'(tag), 2'(s)};
    reqKind = 2'(kind);
    fetchDom = 2'(fd); loadDom = 2'(ld); storeDom = 2'(sd);
  endtask

  task automatic doReq(int tag, int s, int kind, int fd, int ld, int sd, string req);
    @(negedge clk);
    drive(tag, s, kind, fd, ld, sd);
    predict(tag, s, kind, fd, ld, sd);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp(req);
  endtask

  task automatic setMask(int d, int m);
    @(negedge clk);
    cfgWe = 1'b1; cfgDom = 2'(d); cfgMask = 4'(m);
    @(negedge clk);
    cfgWe = 1'b0;
    mMask[d] = 4'(m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        mTag[s][w] = 0; mV[s][w] = 0; mD[s][w] = 0;
        for (int n = 0; n < 4; n++) mT[s][w][n] = 0;
      end
    for (int d = 0; d < 4; d++) mMask[d] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: idle after reset, masks empty
    chk("R1", "rspValid", int'(rspValid), 0);
    chk("R1", "reqReady", int'(reqReady), 1);
    // R8: empty mask gives error and no fill
    doReq(10, 0, 2, 0, 0, 0, "R8");
    chk("R8", "err", int'(rspErr), 1);

    // R4: fills go to lowest invalid way; R8 no fill happened before
    setMask(0, 4'b1111);
    for (int i = 0; i < 4; i++) begin
      doReq(10 + i, 0, 1, 0, 0, 0, "R4");
      chk("R4", "fillWay", int'(rspWay), i);
      chk("R4", "hit", int'(rspHit), 0);
    end
    // R5: tree after touching 0..3 points at way 0
    doReq(14, 0, 1, 0, 0, 0, "R5");
    chk("R5", "victim", int'(rspWay), 0);

    // R7: store hit then evictions report the dirty line
    doReq(11, 0, 2, 0, 0, 0, "R7");
    chk("R7", "storeHitWay", int'(rspWay), 1);
    begin
      bit sawDirty = 0;
      for (int i = 0; i < 6; i++) begin
        doReq(60 + i, 0, 1, 0, 0, 0, "R7");
        if (rspEvictDirty && rspEvictTag == 8'd11) sawDirty = 1;
      end
      chk("R7", "dirtyWriteback", int'(sawDirty), 1);
    end

    // R2: kind selects domain
    setMask(1, 4'b0001);
    setMask(2, 4'b0010);
    setMask(3, 4'b0100);
    doReq(21, 1, 0, 1, 2, 3, "R2");
    chk("R2", "fetchWay", int'(rspWay), 0);
    doReq(21, 1, 1, 1, 2, 3, "R2");
    chk("R2", "loadWay", int'(rspWay), 1);
    chk("R2", "loadHit", int'(rspHit), 0);
    doReq(21, 1, 2, 1, 2, 3, "R2");
    chk("R2", "storeWay", int'(rspWay), 2);
    doReq(21, 1, 3, 1, 2, 3, "R2");
    chk("R2", "altLoadHit", int'(rspHit), 1);
    chk("R2", "altLoadWay", int'(rspWay), 1);

    // R9: mask write in the acceptance cycle uses the old mask
    @(negedge clk);
    drive(50, 1, 1, 0, 2, 0);
    cfgWe = 1'b1; cfgDom = 2'd2; cfgMask = 4'b1000;
    predict(50, 1, 1, 0, 2, 0);
    @(negedge clk);
    reqValid = 1'b0; cfgWe = 1'b0;
    mMask[2] = 4'b1000;
    checkRsp("R9");
    chk("R9", "oldMaskWay", int'(rspWay), 1);
    doReq(51, 1, 1, 0, 2, 0, "R9");
    chk("R9", "newMaskWay", int'(rspWay), 3);

    // R3 / R11: out-of-mask match is a miss, duplicates per domain
    setMask(0, 4'b0011);
    setMask(1, 4'b1100);
    doReq(22, 2, 1, 0, 0, 0, "R3");
    chk("R3", "way", int'(rspWay), 0);
    doReq(22, 2, 1, 0, 1, 0, "R3");
    chk("R3", "foreignMatchHit", int'(rspHit), 0);
    chk("R3", "foreignMatchWay", int'(rspWay), 2);
    doReq(22, 2, 1, 0, 0, 0, "R11");
    chk("R11", "hitOwn0", int'(rspWay), 0);
    doReq(22, 2, 1, 0, 1, 0, "R11");
    chk("R11", "hitOwn1", int'(rspWay), 2);
    chk("R11", "hit", int'(rspHit), 1);

    // R6: shared ways, separate trees
    setMask(0, 4'b1111);
    setMask(1, 4'b1111);
    for (int i = 0; i < 4; i++) doReq(30 + i, 3, 1, 0, 0, 0, "R6");
    doReq(30, 3, 1, 0, 0, 0, "R6");
    doReq(40, 3, 1, 0, 1, 0, "R6");
    chk("R6", "otherDomVictim", int'(rspWay), 0);
    doReq(41, 3, 1, 0, 0, 0, "R6");
    chk("R6", "ownVictim", int'(rspWay), 2);

    // R10: back-pressure holds the response and blocks the next request
    @(negedge clk);
    rspReady = 1'b0;
    drive(70, 2, 1, 0, 0, 0);
    predict(70, 2, 1, 0, 0, 0);
    @(negedge clk);
    drive(71, 2, 2, 0, 0, 1);
    checkRsp("R10");
    chk("R10", "readyBlocked", int'(reqReady), 0);
    @(negedge clk);
    checkRsp("R10");
    chk("R10", "readyStillBlocked", int'(reqReady), 0);
    rspReady = 1'b1;
    predict(71, 2, 2, 0, 0, 1);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R10");

    // R5 / R7 / R3 sweep with mixed masks
    setMask(0, 4'b0011);
    setMask(1, 4'b1100);
    setMask(2, 4'b0110);
    setMask(3, 4'b0000);
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom);
      doReq(r % 6, (r >> 4) & 3, (r >> 8) & 3, (r >> 10) & 3, (r >> 12) & 3,
            (r >> 14) & 3, "R5");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule